// File: doc/BRIEF.md
# Manchester-Coded Auxiliary Link Transmitter

This block sends one message of 1 to 20 bytes over a half-duplex auxiliary link that uses Manchester coding. A divider sets the timing. It turns the system clock into a tick at twice the bit rate, so one tick lasts one half-bit slot. At the intended 2 MHz tick, one bit lasts 1 µs.

A transaction begins with a start pulse. The block first drives a precharge stretch of coded zeros. It then sends a sync pattern, the message bytes and a stop pattern. After that it releases the line so the link can turn around.

The bytes come from an external buffer. The block addresses that buffer through a byte index and reads the addressed byte back in the same cycle. A key-splice mode builds a 9-byte message from three sources: a 4-byte header from the buffer, a 4-byte key word and one final key byte.

Size, divider, precharge, polarity, doubling and key-splice select are all captured when a start is accepted. Each transaction runs on its own captured copy of these settings.

Top module: `mtx_aux_tx`

## Requirements
- R1: Every half-bit slot on `tx_o` lasts exactly `div_i` system clocks. A divider of 0 or 1 gives one clock per slot. The first slot begins in the cycle after the start is accepted.
- R2: Precharge is `pre_i`×2 coded zero bits, which is `pre_i`×2 µs at a 2 MHz tick. With `dbl_pre_i` set the count is doubled. A setting of 0 skips precharge.
- R3: Each coded bit occupies two slots, and the second slot is always the inverse of the first. With `inv_i` clear, a zero is sent as low then high, so a rising edge at mid-bit means zero. With `inv_i` set, a one is sent as low then high.
- R4: The sync pattern follows precharge. It is 16 coded zeros, then 4 slots high, then 4 slots low.
- R5: Data bytes follow sync and are sent most significant bit first. The byte index on `rd_idx_o` runs from 0 up to size−1, and each byte is read from `rd_data_i`.
- R6: The stop pattern follows the data. It is 4 slots high, then 4 slots low. In the cycle after the stop ends, `done_o` pulses for one cycle and `busy_o` and `oe_o` fall.
- R7: `busy_o` and `oe_o` are high from the cycle after an accepted start until the end of the stop pattern. While they are low, `tx_o` is 0.
- R8: A start with size 0 or a size above 20 pulses `err_o` for one cycle and starts no transmission.
- R9: With `key_sel_i` set, the size must be 9, and any other size is treated as in R8. Bytes 0–3 come from buffer indices 0–3. Bytes 4–7 come from `key_hi_i` bits 31:24, 23:16, 15:8 and 7:0, in that order. Byte 8 comes from `key_lo_i`.
- R10: A start pulse during a transaction is ignored and raises no error. Changes to size, divider, precharge, polarity, doubling or key select during a transaction do not affect it.
- R11: After reset, `tx_o`, `oe_o`, `busy_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one transaction |
| size_i | input | 5 | Message byte count, including the header |
| key_sel_i | input | 1 | Take bytes 4–8 from the key inputs |
| div_i | input | 11 | System clocks per half-bit slot |
| pre_i | input | 4 | Precharge length in 2 µs units |
| dbl_pre_i | input | 1 | Double the precharge length |
| inv_i | input | 1 | Invert the Manchester polarity |
| rd_idx_o | output | 5 | Byte index into the message buffer |
| rd_data_i | input | 8 | Buffer byte at `rd_idx_o`, read in the same cycle |
| key_hi_i | input | 32 | Key word for bytes 4–7 |
| key_lo_i | input | 8 | Key byte for byte 8 |
| tx_o | output | 1 | Serial line level |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transaction |
| err_o | output | 1 | One-cycle pulse when a start is rejected |

## Verification
The hardest case to reach is a start request that arrives while a transaction is running and carries values that would be rejected or would change the timing if they were accepted. The stimulus drives a one-cycle start during the data phase. That start carries an illegal size, a new divider, a new polarity and a new precharge, and these new values stay applied until the transaction ends. The cycle-by-cycle reference must then still match every slot of the original transaction and must see no error pulse. Boundary frames add more cases: a 20-byte frame at one clock per slot, the longest doubled precharge, and a slow frame with a divider of 150.

// File: rtl/aux_tx_pkg.sv
package aux_tx_pkg;
   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_PRE     = 3'd1,
      PH_SYNC    = 3'd2,
      PH_SYNC_HI = 3'd3,
      PH_SYNC_LO = 3'd4,
      PH_DATA    = 3'd5,
      PH_STOP_HI = 3'd6,
      PH_STOP_LO = 3'd7
   } aux_phase_e;

   // coded zeros in the sync run
   localparam int unsigned SYNC_ZERO_BITS = 16;
   // bit times of each fixed high or low level
   localparam int unsigned LEVEL_BITS     = 2;
endpackage

// File: rtl/aux_tick_gen.sv
module aux_tick_gen #(
   parameter int unsigned DIV_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   // a divider of 0 or 1 ticks on every clock
   assign tick_o = (div_i <= DIV_W'(1)) || (cnt_q == div_i - DIV_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/aux_byte_src.sv
module aux_byte_src #(
   parameter bit          KEY_EN       = 1'b1,
   parameter int unsigned IDX_W        = 5,
   parameter int unsigned HDR_BYTES    = 4,
   parameter int unsigned KEY_HI_BYTES = 4
) (
   input  logic [IDX_W-1:0]          idx_i,
   input  logic                      key_sel_i,
   input  logic [7:0]                rd_data_i,
   input  logic [8*KEY_HI_BYTES-1:0] key_hi_i,
   input  logic [7:0]                key_lo_i,
   output logic [7:0]                byte_o
);
   localparam int unsigned KEY_LO_IDX = HDR_BYTES + KEY_HI_BYTES;

   if (KEY_EN) begin : g_splice
      always_comb begin
         byte_o = rd_data_i;
         if (key_sel_i) begin
            for (int k = 0; k < KEY_HI_BYTES; k++) begin
               if (idx_i == IDX_W'(HDR_BYTES + k)) begin
                  byte_o = key_hi_i[8*(KEY_HI_BYTES-1-k) +: 8];
               end
            end
            if (idx_i == IDX_W'(KEY_LO_IDX)) begin
               byte_o = key_lo_i;
            end
         end
      end
   end else begin : g_plain
      assign byte_o = rd_data_i;
   end
endmodule

// File: rtl/aux_tx_seq.sv
module aux_tx_seq
   import aux_tx_pkg::*;
#(
   parameter int unsigned SIZE_W        = 5,
   parameter int unsigned MAX_BYTES     = 20,
   parameter int unsigned PRE_W         = 4,
   parameter bit          KEY_EN        = 1'b1,
   parameter int unsigned KEY_MSG_BYTES = 9,
   parameter int unsigned LEN_W         = SIZE_W + 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              key_sel_i,
   input  logic [PRE_W-1:0]  pre_i,
   input  logic              dbl_pre_i,
   input  logic              tick_i,
   output aux_phase_e        phase_o,
   output logic [LEN_W-1:0]  bit_cnt_o,
   output logic              half_o,
   output logic              accept_o,
   output logic              done_o,
   output logic              err_o
);
   aux_phase_e        phase_q, phase_nxt;
   logic [LEN_W-1:0]  cnt_q, len;
   logic [LEN_W-1:0]  pre_bits_q, pre_bits_in;
   logic [SIZE_W-1:0] size_q;
   logic              half_q, legal, slot_last;

   assign legal = (size_i != '0) && (size_i <= SIZE_W'(MAX_BYTES)) &&
                  (!KEY_EN || !key_sel_i || size_i == SIZE_W'(KEY_MSG_BYTES));
   assign pre_bits_in = LEN_W'({pre_i, 1'b0}) << dbl_pre_i;
   assign accept_o    = (phase_q == PH_IDLE) && start_i && legal;

   always_comb begin
      unique case (phase_q)
         PH_PRE:  len = pre_bits_q;
         PH_SYNC: len = LEN_W'(SYNC_ZERO_BITS);
         PH_DATA: len = LEN_W'({size_q, 3'b000});
         PH_IDLE: len = LEN_W'(1);
         default: len = LEN_W'(LEVEL_BITS);
      endcase
   end

   always_comb begin
      unique case (phase_q)
         PH_PRE:     phase_nxt = PH_SYNC;
         PH_SYNC:    phase_nxt = PH_SYNC_HI;
         PH_SYNC_HI: phase_nxt = PH_SYNC_LO;
         PH_SYNC_LO: phase_nxt = PH_DATA;
         PH_DATA:    phase_nxt = PH_STOP_HI;
         PH_STOP_HI: phase_nxt = PH_STOP_LO;
         default:    phase_nxt = PH_IDLE;
      endcase
   end

   assign slot_last = half_q && (cnt_q == len - LEN_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q    <= PH_IDLE;
         cnt_q      <= '0;
         half_q     <= 1'b0;
         pre_bits_q <= '0;
         size_q     <= '0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (start_i && !legal) begin
               err_o <= 1'b1;
            end else if (accept_o) begin
               size_q     <= size_i;
               pre_bits_q <= pre_bits_in;
               cnt_q      <= '0;
               half_q     <= 1'b0;
               phase_q    <= (pre_bits_in == '0) ? PH_SYNC : PH_PRE;
            end
         end else if (tick_i) begin
            if (!half_q) begin
               half_q <= 1'b1;
            end else if (slot_last) begin
               half_q  <= 1'b0;
               cnt_q   <= '0;
               phase_q <= phase_nxt;
               if (phase_nxt == PH_IDLE) done_o <= 1'b1;
            end else begin
               half_q <= 1'b0;
               cnt_q  <= cnt_q + LEN_W'(1);
            end
         end
      end
   end

   assign phase_o   = phase_q;
   assign bit_cnt_o = cnt_q;
   assign half_o    = half_q;
endmodule

// File: rtl/mtx_aux_tx.sv
module mtx_aux_tx
   import aux_tx_pkg::*;
#(
   parameter int unsigned SIZE_W       = 5,
   parameter int unsigned MAX_BYTES    = 20,
   parameter int unsigned DIV_W        = 11,
   parameter int unsigned PRE_W        = 4,
   parameter bit          KEY_EN       = 1'b1,
   parameter int unsigned HDR_BYTES    = 4,
   parameter int unsigned KEY_HI_BYTES = 4
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      start_i,
   input  logic [SIZE_W-1:0]         size_i,
   input  logic                      key_sel_i,
   input  logic [DIV_W-1:0]          div_i,
   input  logic [PRE_W-1:0]          pre_i,
   input  logic                      dbl_pre_i,
   input  logic                      inv_i,
   output logic [SIZE_W-1:0]         rd_idx_o,
   input  logic [7:0]                rd_data_i,
   input  logic [8*KEY_HI_BYTES-1:0] key_hi_i,
   input  logic [7:0]                key_lo_i,
   output logic                      tx_o,
   output logic                      oe_o,
   output logic                      busy_o,
   output logic                      done_o,
   output logic                      err_o
);
   localparam int unsigned LEN_W         = SIZE_W + 3;
   localparam int unsigned KEY_MSG_BYTES = HDR_BYTES + KEY_HI_BYTES + 1;

   if (MAX_BYTES < 1 || MAX_BYTES >= (1 << SIZE_W)) begin : g_bad_size
      $error("MAX_BYTES must be at least 1 and below 2**SIZE_W");
   end
   if (PRE_W + 2 > LEN_W) begin : g_bad_pre
      $error("precharge bit count does not fit the bit counter");
   end
   if (KEY_EN && KEY_MSG_BYTES > MAX_BYTES) begin : g_bad_key
      $error("key-splice message exceeds MAX_BYTES");
   end

   aux_phase_e       phase;
   logic [LEN_W-1:0] bit_cnt;
   logic             half, tick, accept;
   logic [DIV_W-1:0] div_q;
   logic             inv_q, key_sel_q;
   logic [7:0]       cur_byte;
   logic             data_bit, first_lvl;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q     <= '0;
         inv_q     <= 1'b0;
         key_sel_q <= 1'b0;
      end else if (accept) begin
         div_q     <= div_i;
         inv_q     <= inv_i;
         key_sel_q <= key_sel_i;
      end
   end

   aux_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (accept),
      .div_i  (div_q),
      .tick_o (tick)
   );

   aux_tx_seq #(
      .SIZE_W        (SIZE_W),
      .MAX_BYTES     (MAX_BYTES),
      .PRE_W         (PRE_W),
      .KEY_EN        (KEY_EN),
      .KEY_MSG_BYTES (KEY_MSG_BYTES),
      .LEN_W         (LEN_W)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .size_i    (size_i),
      .key_sel_i (key_sel_i),
      .pre_i     (pre_i),
      .dbl_pre_i (dbl_pre_i),
      .tick_i    (tick),
      .phase_o   (phase),
      .bit_cnt_o (bit_cnt),
      .half_o    (half),
      .accept_o  (accept),
      .done_o    (done_o),
      .err_o     (err_o)
   );

   assign rd_idx_o = bit_cnt[LEN_W-1:3];

   aux_byte_src #(
      .KEY_EN       (KEY_EN),
      .IDX_W        (SIZE_W),
      .HDR_BYTES    (HDR_BYTES),
      .KEY_HI_BYTES (KEY_HI_BYTES)
   ) u_src (
      .idx_i     (rd_idx_o),
      .key_sel_i (key_sel_q),
      .rd_data_i (rd_data_i),
      .key_hi_i  (key_hi_i),
      .key_lo_i  (key_lo_i),
      .byte_o    (cur_byte)
   );

   assign data_bit = cur_byte[3'd7 - bit_cnt[2:0]];

   always_comb begin
      first_lvl = 1'b0;
      tx_o      = 1'b0;
      unique case (phase)
         PH_PRE, PH_SYNC: begin
            first_lvl = inv_q;
            tx_o      = half ? ~first_lvl : first_lvl;
         end
         PH_DATA: begin
            first_lvl = data_bit ^ inv_q;
            tx_o      = half ? ~first_lvl : first_lvl;
         end
         PH_SYNC_HI, PH_STOP_HI: tx_o = 1'b1;
         default:                tx_o = 1'b0;
      endcase
   end

   assign busy_o = (phase != PH_IDLE);
   assign oe_o   = busy_o;
endmodule

// File: rtl/aux_tx_chk.sv
module aux_tx_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic start_i,
   input logic tx_o,
   input logic oe_o,
   input logic busy_o,
   input logic done_o,
   input logic err_o
);
   // R7: a transaction only opens after a start request
   assert_busy_needs_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(start_i));

   // R7: the line rests low while the driver is released
   assert_idle_line_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_o |-> !tx_o);

   // R6: done marks the cycle right after the last busy cycle
   assert_done_closes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && $past(busy_o)));

   // R8: a rejection answers a start and launches nothing
   assert_err_no_launch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> (!busy_o && !oe_o && $past(start_i) && !$past(busy_o)));

   // R10: a start during a transaction is never rejected
   assert_busy_start_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> !err_o);

   // R6, R8: completion and rejection never coincide
   assert_done_err_apart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(done_o && err_o));
endmodule

bind mtx_aux_tx aux_tx_chk u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .tx_o    (tx_o),
   .oe_o    (oe_o),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .err_o   (err_o)
);

// File: tb/mtx_aux_tx_tb_top.sv
module mtx_aux_tx_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  size = '0;
   logic        key_sel = 1'b0;
   logic [10:0] div = '0;
   logic [3:0]  pre = '0;
   logic        dbl = 1'b0;
   logic        inv = 1'b0;
   logic [4:0]  rd_idx;
   logic [7:0]  rd_data;
   logic [31:0] key_hi = 32'hA1B2_C3D4;
   logic [7:0]  key_lo = 8'h5E;
   logic        tx, oe, busy, done, err;
   logic [7:0]  buf_mem [0:31];

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   bit    run_chk = 1'b0;
   string cur_req = "R11";

   // reference model state
   bit m_busy = 1'b0;
   bit e_done = 1'b0;
   bit e_err  = 1'b0;
   bit mq[$];
   int m_cyc = 0;
   int m_div = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rd_data = buf_mem[rd_idx];

   mtx_aux_tx dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .size_i    (size),
      .key_sel_i (key_sel),
      .div_i     (div),
      .pre_i     (pre),
      .dbl_pre_i (dbl),
      .inv_i     (inv),
      .rd_idx_o  (rd_idx),
      .rd_data_i (rd_data),
      .key_hi_i  (key_hi),
      .key_lo_i  (key_lo),
      .tx_o      (tx),
      .oe_o      (oe),
      .busy_o    (busy),
      .done_o    (done),
      .err_o     (err)
   );

   function automatic void push_bit(bit v, bit pol);
      mq.push_back(v ^ pol);
      mq.push_back(!(v ^ pol));
   endfunction

   function automatic void push_level(bit lvl);
      for (int i = 0; i < 4; i++) mq.push_back(lvl);
   endfunction

   function automatic logic [7:0] msg_byte(int j);
      if (key_sel && j >= 4 && j < 8) return key_hi[8*(7-j) +: 8];
      if (key_sel && j == 8) return key_lo;
      return buf_mem[j];
   endfunction

   // behavioural reference: a queue of half-bit slot levels
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 1'b0; e_done = 1'b0; e_err = 1'b0; mq.delete(); m_cyc = 0;
      end else begin
         e_done = 1'b0;
         e_err  = 1'b0;
         if (m_busy) begin
            m_cyc++;
            if (m_cyc == m_div) begin
               m_cyc = 0;
               void'(mq.pop_front());
               if (mq.size() == 0) begin
                  m_busy = 1'b0;
                  e_done = 1'b1;
               end
            end
         end else if (start) begin
            if (size == 0 || size > 20 || (key_sel && size != 9)) begin
               e_err = 1'b1;
            end else begin
               m_div = (div <= 1) ? 1 : int'(div);
               for (int i = 0; i < int'(pre) * 2 * (dbl ? 2 : 1); i++) push_bit(1'b0, inv);
               for (int i = 0; i < 16; i++) push_bit(1'b0, inv);
               push_level(1'b1);
               push_level(1'b0);
               for (int j = 0; j < int'(size); j++) begin
                  logic [7:0] b;
                  b = msg_byte(j);
                  for (int k = 7; k >= 0; k--) push_bit(b[k], inv);
               end
               push_level(1'b1);
               push_level(1'b0);
               m_busy = 1'b1;
               m_cyc  = 0;
            end
         end
      end
   end

   task automatic check1(input logic act, input logic exp, input string nm);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run_chk) begin
         check1(tx,   m_busy ? mq[0] : 1'b0, "tx_o");
         check1(oe,   m_busy, "oe_o");
         check1(busy, m_busy, "busy_o");
         check1(done, e_done, "done_o");
         check1(err,  e_err,  "err_o");
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   task automatic fill_buf(input int seed);
      for (int i = 0; i < 32; i++) buf_mem[i] = 8'((i * 37 + seed * 11 + 5) ^ (seed * 3));
   endtask

   task automatic send(input int sz, input int dv, input int pr, input bit iv,
                       input bit db, input bit ks, input string req);
      @(negedge clk);
      cur_req = req;
      size = 5'(sz); div = 11'(dv); pre = 4'(pr); inv = iv; dbl = db; key_sel = ks;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      fill_buf(1);
      run_chk = 1'b1;
      // R11: outputs during and just after reset
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 R2 R3 R4 R5 R6 R7: plain frame
      send(3, 2, 5, 1'b0, 1'b0, 1'b0, "R2_R4_R5_R6_R7");
      // R3: inverted polarity, R2: doubled precharge
      fill_buf(2);
      send(4, 3, 2, 1'b1, 1'b1, 1'b0, "R3_R2");
      // R1: divider 0, R2: no precharge, R5: largest message
      fill_buf(3);
      send(20, 0, 0, 1'b0, 1'b0, 1'b0, "R1_R5");
      // R2: longest doubled precharge with divider 1
      send(2, 1, 15, 1'b1, 1'b1, 1'b0, "R2");
      // R8: illegal sizes
      send(0, 2, 3, 1'b0, 1'b0, 1'b0, "R8");
      send(21, 2, 3, 1'b0, 1'b0, 1'b0, "R8");
      send(31, 2, 3, 1'b0, 1'b0, 1'b0, "R8");
      // R9: key splice with size 9, and a rejected size
      fill_buf(4);
      send(9, 2, 1, 1'b0, 1'b0, 1'b1, "R9");
      send(9, 1, 0, 1'b1, 1'b0, 1'b1, "R9");
      send(5, 2, 1, 1'b0, 1'b0, 1'b1, "R9");

      // R10: start and new settings during a transaction
      @(negedge clk);
      cur_req = "R10";
      size = 5'd2; div = 11'd2; pre = 4'd1; inv = 1'b0; dbl = 1'b0; key_sel = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (90) @(negedge clk);
      size = 5'd0; div = 11'd5; pre = 4'd9; inv = 1'b1; dbl = 1'b1; key_sel = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (7) @(negedge clk);
      size = 5'd7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);

      // R1: slow divider
      fill_buf(5);
      send(1, 150, 0, 1'b0, 1'b0, 1'b0, "R1");

      run_chk = 1'b0;
      finish_run();
   end
endmodule